// File: doc/BRIEF.md
# DRAM Row/Column Address Multiplexer

This block turns one CPU access into the address and strobe pattern for a DRAM with a 9-bit multiplexed address bus. The access address has 18 bits in total. Thirteen bits are an offset within a page, taken from the CPU. Five bits are a bank number, which an external page-mapping unit supplies. The block first presents the row half of the address and drops RAS. It then switches the bus to the column half and drops CAS. Bit 0 of the offset is never placed on the bus. It chooses which byte write enable, even or odd, is driven on a write.

All timing runs on a fast internal clock. The bus-phase signal E is sampled on that clock. A request seen when E rises starts one access, and the access is cut short as soon as E is sampled low again. The row setup, the row hold and the column setup are parameters counted in internal clock cycles. The bank lookup itself, DRAM refresh and video-fetch arbitration are handled elsewhere.

The bit routing is irregular. The most significant bank bit is driven on the top bus bit in both the row and the column phase. The lower four bank bits occupy column bits 4 to 7.

Top module: `dram_rowcol_mux`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block drives `ras_n`, `cas_n`, `we_even_n` and `we_odd_n` high and `dram_addr` to zero after that edge.
- R2: Row mapping. During the row phase, `dram_addr[7:0]` equals offset bits 8..1 and `dram_addr[8]` equals bank bit 4.
- R3: Column mapping. During the column phase, `dram_addr[3:0]` equals offset bits 12..9, `dram_addr[7:4]` equals bank bits 3..0 and `dram_addr[8]` equals bank bit 4.
- R4: On a write, offset bit 0 picks the write enable: 0 drives `we_even_n` low and 1 drives `we_odd_n` low. The two enables are never low together.
- R5: On a read (`wr` = 0), both write enables stay high for the whole access.
- R6: An access starts at the edge where `e_phase` is sampled high after having been sampled low, with `req` high. Counting edges from that edge, RAS falls after ROW_SETUP_CYC edges. The bus switches to the column after ROW_HOLD_CYC further edges, and the write enable asserts at the same edge. CAS falls after COL_SETUP_CYC further edges.
- R7: At the first edge where `e_phase` is sampled low, RAS, CAS and both write enables return high. The write enable is released no later than CAS.
- R8: If `req` is low at the edge where E rises, no strobe is driven during that E-high phase, even if `req` rises later in the phase.
- R9: CAS is never low while RAS is high. RAS is low only in a cycle that follows an edge where `e_phase` was sampled high.
- R10: The offset, the bank and `wr` are captured only at the start edge. Changes during the phase do not alter the bus or the write enables. Outside an access, the bus shows the row of the last captured address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal timing clock |
| rst_n | input | 1 | Synchronous active-low reset |
| e_phase | input | 1 | Bus-phase clock E, sampled on `clk` |
| req | input | 1 | CPU access request, sampled when E rises |
| wr | input | 1 | 1 = write access, 0 = read access |
| cpu_ofs | input | 13 | In-page offset A12..A0 |
| bank_sel | input | 5 | Bank number from the page-mapping unit |
| dram_addr | output | 9 | Multiplexed DRAM address bus |
| ras_n | output | 1 | Row address strobe, active low |
| cas_n | output | 1 | Column address strobe, active low |
| we_even_n | output | 1 | Even-byte write enable, active low |
| we_odd_n | output | 1 | Odd-byte write enable, active low |

## Verification
The bench builds the block with ROW_SETUP_CYC = 2, ROW_HOLD_CYC = 2 and COL_SETUP_CYC = 1. With these values the down-counter is reloaded and counted down in the setup state and in the hold state, and it also takes the single-cycle path. E-high phases of 12 cycles let every access run through to CAS. Phases of 3 and 5 cycles end the access before the column switch and just after it. An 18-bit reconstruction from the captured row, the captured column and the active write enable covers all 32 banks under varied offset patterns.

// File: rtl/dram_rowcol_pkg.sv
// Shared types for the DRAM row/column multiplexer.
// Assumes: one access sequence per E-high phase.
package dram_rowcol_pkg;

    // Phases of one access, in the order they occur.
    typedef enum logic [2:0] {
        SQ_IDLE    = 3'd0,
        SQ_SETUP   = 3'd1,
        SQ_ROWHOLD = 3'd2,
        SQ_COLSET  = 3'd3,
        SQ_COLACT  = 3'd4
    } seq_state_t;

endpackage

// File: rtl/dram_rc_map.sv
// Combinational split of a captured offset/bank pair into row and column words.
// Assumes: offset bit 0 is a byte select and never appears on the bus.
// The row carries offset bits above bit 0 plus the top bank bit. The column
// carries the remaining offset bits, then the lower bank bits, then the top bank bit again.
module dram_rc_map #(
    parameter int OFS_W  = 13,
    parameter int BANK_W = 5,
    parameter int BUS_W  = 9
) (
    input  logic [OFS_W-1:0]  ofs,
    input  logic [BANK_W-1:0] bank,
    output logic [BUS_W-1:0]  row_word,
    output logic [BUS_W-1:0]  col_word
);
    localparam int ROW_OFS_N = BUS_W - 1;
    localparam int COL_OFS_N = OFS_W - 1 - ROW_OFS_N;
    localparam int COL_BNK_N = BANK_W - 1;

    // Row bits: offset bits 1..ROW_OFS_N in order.
    for (genvar i = 0; i < ROW_OFS_N; i++) begin : g_row
        assign row_word[i] = ofs[i+1];
    end
    // Row top bit: most significant bank bit.
    assign row_word[BUS_W-1] = bank[BANK_W-1];

    // Column low bits: upper offset bits in order.
    for (genvar i = 0; i < COL_OFS_N; i++) begin : g_col_ofs
        assign col_word[i] = ofs[ROW_OFS_N+1+i];
    end
    // Column middle bits: lower bank bits in order.
    for (genvar j = 0; j < COL_BNK_N; j++) begin : g_col_bank
        assign col_word[COL_OFS_N+j] = bank[j];
    end
    // Column top bit: most significant bank bit repeated.
    assign col_word[BUS_W-1] = bank[BANK_W-1];

endmodule

// File: rtl/dram_strobe_seq.sv
// Strobe sequencer driven by the sampled bus-phase signal E.
// Assumes: all timing parameters are >= 1. E is synchronous to clk.
// Starts an access on the edge that sees E rise with a request present.
// Walks setup, row hold, column setup and column active. Returns idle
// whenever E is sampled low.
module dram_strobe_seq
    import dram_rowcol_pkg::*;
#(
    parameter int ROW_SETUP_CYC = 1,
    parameter int ROW_HOLD_CYC  = 2,
    parameter int COL_SETUP_CYC = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic e_phase,
    input  logic req,
    output logic start,
    output logic ras_act,
    output logic cas_act,
    output logic col_sel
);
    localparam int MAX_CYC = (ROW_SETUP_CYC > ROW_HOLD_CYC)
                           ? ((ROW_SETUP_CYC > COL_SETUP_CYC) ? ROW_SETUP_CYC : COL_SETUP_CYC)
                           : ((ROW_HOLD_CYC  > COL_SETUP_CYC) ? ROW_HOLD_CYC  : COL_SETUP_CYC);
    localparam int CNT_W = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
    localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(ROW_SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] LD_HOLD  = CNT_W'(ROW_HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] LD_COL   = CNT_W'(COL_SETUP_CYC - 1);

    seq_state_t       st;
    logic [CNT_W-1:0] cnt;
    logic             e_d;
    logic             e_rise;

    // Rising edge of the sampled phase signal.
    assign e_rise = e_phase && !e_d;
    // Start pulse: idle, E just rose, request present.
    assign start  = (st == SQ_IDLE) && e_rise && req;

    // Phase sampler, state register and interval counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_d <= 1'b0;
            st  <= SQ_IDLE;
            cnt <= '0;
        end else begin
            e_d <= e_phase;
            if (!e_phase) begin
                st  <= SQ_IDLE;
                cnt <= '0;
            end else begin
                unique case (st)
                    SQ_IDLE: begin
                        if (start) begin
                            st  <= SQ_SETUP;
                            cnt <= LD_SETUP;
                        end
                    end
                    SQ_SETUP: begin
                        if (cnt == '0) begin
                            st  <= SQ_ROWHOLD;
                            cnt <= LD_HOLD;
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                    SQ_ROWHOLD: begin
                        if (cnt == '0) begin
                            st  <= SQ_COLSET;
                            cnt <= LD_COL;
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                    SQ_COLSET: begin
                        if (cnt == '0) begin
                            st <= SQ_COLACT;
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                    SQ_COLACT: st <= SQ_COLACT;
                    default:   st <= SQ_IDLE;
                endcase
            end
        end
    end

    // Strobe and bus-select decode from the current state.
    always_comb begin
        ras_act = (st == SQ_ROWHOLD) || (st == SQ_COLSET) || (st == SQ_COLACT);
        cas_act = (st == SQ_COLACT);
        col_sel = (st == SQ_COLSET) || (st == SQ_COLACT);
    end

endmodule

// File: rtl/dram_access_latch.sv
// Holds the offset, bank and direction of the access in progress.
// Assumes: load is a one-cycle pulse at the start of an access.
module dram_access_latch #(
    parameter int OFS_W  = 13,
    parameter int BANK_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [OFS_W-1:0]  ofs_in,
    input  logic [BANK_W-1:0] bank_in,
    input  logic              wr_in,
    output logic [OFS_W-1:0]  ofs_q,
    output logic [BANK_W-1:0] bank_q,
    output logic              wr_q
);
    // Capture the access fields on the start pulse only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs_q  <= '0;
            bank_q <= '0;
            wr_q   <= 1'b0;
        end else if (load) begin
            ofs_q  <= ofs_in;
            bank_q <= bank_in;
            wr_q   <= wr_in;
        end
    end

endmodule

// File: rtl/dram_rowcol_mux.sv
// Top level: forms the multiplexed DRAM address and the RAS/CAS/byte-write strobes
// for one CPU access per E-high phase.
// Assumes: synchronous active-low reset; e_phase, req, wr and address are synchronous to clk.
module dram_rowcol_mux #(
    parameter int OFS_W         = 13,
    parameter int BANK_W        = 5,
    parameter int BUS_W         = 9,
    parameter int ROW_SETUP_CYC = 1,
    parameter int ROW_HOLD_CYC  = 2,
    parameter int COL_SETUP_CYC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              e_phase,
    input  logic              req,
    input  logic              wr,
    input  logic [OFS_W-1:0]  cpu_ofs,
    input  logic [BANK_W-1:0] bank_sel,
    output logic [BUS_W-1:0]  dram_addr,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_even_n,
    output logic              we_odd_n
);
    logic              start;
    logic              ras_act;
    logic              cas_act;
    logic              col_sel;
    logic [OFS_W-1:0]  ofs_q;
    logic [BANK_W-1:0] bank_q;
    logic              wr_q;
    logic [BUS_W-1:0]  row_word;
    logic [BUS_W-1:0]  col_word;
    logic              we_act;

    dram_strobe_seq #(
        .ROW_SETUP_CYC (ROW_SETUP_CYC),
        .ROW_HOLD_CYC  (ROW_HOLD_CYC),
        .COL_SETUP_CYC (COL_SETUP_CYC)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .e_phase (e_phase),
        .req     (req),
        .start   (start),
        .ras_act (ras_act),
        .cas_act (cas_act),
        .col_sel (col_sel)
    );

    dram_access_latch #(
        .OFS_W  (OFS_W),
        .BANK_W (BANK_W)
    ) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (start),
        .ofs_in  (cpu_ofs),
        .bank_in (bank_sel),
        .wr_in   (wr),
        .ofs_q   (ofs_q),
        .bank_q  (bank_q),
        .wr_q    (wr_q)
    );

    dram_rc_map #(
        .OFS_W  (OFS_W),
        .BANK_W (BANK_W),
        .BUS_W  (BUS_W)
    ) u_map (
        .ofs      (ofs_q),
        .bank     (bank_q),
        .row_word (row_word),
        .col_word (col_word)
    );

    // Bus select, active-low strobes and byte-lane write enable steering.
    always_comb begin
        dram_addr = col_sel ? col_word : row_word;
        we_act    = col_sel && wr_q;
        ras_n     = !ras_act;
        cas_n     = !cas_act;
        we_even_n = !(we_act && !ofs_q[0]);
        we_odd_n  = !(we_act &&  ofs_q[0]);
    end

endmodule

// File: rtl/dram_rowcol_mux_chk.sv
// Protocol checker for dram_rowcol_mux, bound into every instance.
// Assumes: synchronous active-low reset on the same clock.
module dram_rowcol_mux_chk #(
    parameter int BUS_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             e_phase,
    input logic [BUS_W-1:0] dram_addr,
    input logic             ras_n,
    input logic             cas_n,
    input logic             we_even_n,
    input logic             we_odd_n
);
    // R9: CAS only with RAS.
    assert_cas_needs_ras_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n);

    // R9: RAS low only after an edge that saw E high.
    assert_ras_in_e_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> $past(e_phase));

    // R4: byte write enables are exclusive.
    assert_we_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_even_n && !we_odd_n));

    // R6: a write enable only inside a RAS cycle.
    assert_we_inside_ras_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_even_n || !we_odd_n) |-> !ras_n);

    // R2: row on the bus already before RAS falls.
    assert_row_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> $stable(dram_addr));

    // R2: row held for at least one cycle after RAS falls.
    assert_row_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |=> $stable(dram_addr));

    // R3: column on the bus before CAS falls.
    assert_col_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> $stable(dram_addr));

    // R7: write enables released together with CAS.
    assert_we_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_n) |-> (we_even_n && we_odd_n));

endmodule

bind dram_rowcol_mux dram_rowcol_mux_chk #(.BUS_W(BUS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .e_phase   (e_phase),
    .dram_addr (dram_addr),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_even_n (we_even_n),
    .we_odd_n  (we_odd_n)
);

// File: tb/dram_rowcol_mux_bench.sv
// Self-checking bench: a behavioural per-cycle model plus address reconstruction.
module dram_rowcol_mux_bench;
    localparam int RS = 2;
    localparam int RH = 2;
    localparam int CS = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        e_phase = 1'b0;
    logic        req = 1'b0;
    logic        wr = 1'b0;
    logic [12:0] cpu_ofs = '0;
    logic [4:0]  bank_sel = '0;
    logic [8:0]  dram_addr;
    logic        ras_n, cas_n, we_even_n, we_odd_n;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #2.5 clk = ~clk;

    dram_rowcol_mux #(
        .ROW_SETUP_CYC (RS),
        .ROW_HOLD_CYC  (RH),
        .COL_SETUP_CYC (CS)
    ) u_dram_rowcol_mux (
        .clk (clk), .rst_n (rst_n), .e_phase (e_phase), .req (req), .wr (wr),
        .cpu_ofs (cpu_ofs), .bank_sel (bank_sel), .dram_addr (dram_addr),
        .ras_n (ras_n), .cas_n (cas_n), .we_even_n (we_even_n), .we_odd_n (we_odd_n)
    );

    // Behavioural model state.
    bit          m_active = 0;
    bit          m_ewas   = 0;
    bit          m_ended  = 0;
    int          m_t      = 0;
    logic [12:0] m_ofs    = '0;
    logic [4:0]  m_bank   = '0;
    bit          m_wr     = 0;

    always @(posedge clk) begin
        cycles++;
        m_ended = 0;
        if (!rst_n) begin
            m_active = 0; m_ewas = 0; m_t = 0; m_ofs = '0; m_bank = '0; m_wr = 0;
        end else begin
            if (!e_phase) begin
                m_ended  = m_active;
                m_active = 0;
            end else if (!m_ewas && req) begin
                m_active = 1; m_t = 0; m_ofs = cpu_ofs; m_bank = bank_sel; m_wr = wr;
            end else if (m_active) begin
                m_t++;
            end
            m_ewas = e_phase;
        end
    end

    function automatic logic [8:0] row_of(logic [12:0] o, logic [4:0] b);
        return {b[4], o[8:1]};
    endfunction
    function automatic logic [8:0] col_of(logic [12:0] o, logic [4:0] b);
        return {b[4], b[3:0], o[12:9]};
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Reconstruction bookkeeping.
    logic       prev_ras = 1'b1, prev_cas = 1'b1;
    logic [8:0] cap_row = '0;

    task automatic compare();
        bit exp_ras, exp_cas, exp_col, exp_we_e, exp_we_o;
        logic [8:0]  exp_addr;
        logic [12:0] rec_ofs;
        logic [4:0]  rec_bank;
        string tstrobe, taddr, twe;
        exp_ras = 1; exp_cas = 1; exp_col = 0;
        if (m_active) begin
            if (m_t < RS) begin
                exp_ras = 1;
            end else if (m_t < RS + RH) begin
                exp_ras = 0;
            end else if (m_t < RS + RH + CS) begin
                exp_ras = 0; exp_col = 1;
            end else begin
                exp_ras = 0; exp_col = 1; exp_cas = 0;
            end
        end
        exp_addr = exp_col ? col_of(m_ofs, m_bank) : row_of(m_ofs, m_bank);
        exp_we_e = !(exp_col && m_wr && !m_ofs[0]);
        exp_we_o = !(exp_col && m_wr &&  m_ofs[0]);
        tstrobe  = !rst_n ? "R1" : (m_ended ? "R7" : "R6");
        taddr    = !rst_n ? "R1" : (exp_col ? "R3" : "R2");
        twe      = !rst_n ? "R1" : (m_wr ? "R4" : "R5");
        chk(ras_n === exp_ras, {tstrobe, " ras_n"}, ras_n, exp_ras);
        chk(cas_n === exp_cas, {tstrobe, " cas_n"}, cas_n, exp_cas);
        chk(dram_addr === exp_addr, {taddr, " dram_addr"}, dram_addr, exp_addr);
        chk(we_even_n === exp_we_e, {twe, " we_even_n"}, we_even_n, exp_we_e);
        chk(we_odd_n === exp_we_o, {twe, " we_odd_n"}, we_odd_n, exp_we_o);
        // R9: no CAS without RAS.
        chk(!(cas_n === 1'b0 && ras_n === 1'b1), "R9 cas without ras", cas_n, 1);
        // Reconstruct the address from the bus at the strobe falls.
        if (prev_ras && !ras_n) cap_row = dram_addr;
        if (prev_cas && !cas_n) begin
            rec_ofs  = {dram_addr[3:0], cap_row[7:0], 1'b0};
            rec_bank = {cap_row[8], dram_addr[7:4]};
            if (m_wr) rec_ofs[0] = !we_odd_n;
            else      rec_ofs[0] = m_ofs[0];
            chk(rec_ofs === m_ofs, "R2 R3 R4 rebuilt offset", rec_ofs, m_ofs);
            chk(rec_bank === m_bank && dram_addr[8] === cap_row[8],
                "R3 rebuilt bank", rec_bank, m_bank);
        end
        prev_ras = ras_n;
        prev_cas = cas_n;
    endtask

    task automatic tick();
        @(negedge clk);
        compare();
    endtask

    // One E period: low with inputs set, high for hi cycles, then back low.
    task automatic access(bit r, bit w, logic [12:0] o, logic [4:0] b, int hi,
                          bit mid_change, bit mid_req);
        req = r; wr = w; cpu_ofs = o; bank_sel = b; e_phase = 0;
        repeat (4) tick();
        e_phase = 1;
        for (int i = 0; i < hi; i++) begin
            tick();
            if (i == 1 && mid_change) begin
                cpu_ofs = ~o; bank_sel = ~b; wr = !w;   // R10: ignored mid-phase
            end
            if (i == 1 && mid_req) req = 1;             // R8: late request ignored
        end
        e_phase = 0; req = 0;
        tick();
    endtask

    // Watchdog.
    initial begin
        wait (cycles > 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [12:0] pat;
        // R1: reset state.
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R2 R3 R4 R5 R6: sweep every bank with varied offsets, writes and reads.
        pat = 13'h0A5B;
        for (int b = 0; b < 32; b++) begin
            for (int k = 0; k < 4; k++) begin
                pat = {pat[11:0], pat[12] ^ pat[9] ^ pat[3]} ^ 13'(b * 37 + k);
                access(1, (k % 2) == 0, (k == 3) ? (13'h1 << (b % 13)) : pat,
                       5'(b), 12, 0, 0);
            end
        end
        access(1, 1, 13'h1FFF, 5'h1F, 12, 0, 0);
        access(1, 1, 13'h0000, 5'h00, 12, 0, 0);
        access(1, 0, 13'h1555, 5'h15, 12, 0, 0);
        // R8: no request at the rise, request raised later.
        access(0, 1, 13'h0123, 5'h07, 12, 0, 1);
        // R10: address, bank and direction changed mid-phase.
        access(1, 1, 13'h0F0E, 5'h0A, 12, 1, 0);
        access(1, 0, 13'h1001, 5'h11, 12, 1, 0);
        // R7: short phases cut the access before and after the column switch.
        access(1, 1, 13'h0777, 5'h1C, 3, 0, 0);
        access(1, 1, 13'h0778, 5'h03, 5, 0, 0);
        access(1, 1, 13'h0779, 5'h13, 6, 0, 0);
        // R1: reset in the middle of an access.
        req = 1; wr = 1; cpu_ofs = 13'h1ABC; bank_sel = 5'h19; e_phase = 0;
        repeat (2) tick();
        e_phase = 1;
        repeat (6) tick();
        rst_n = 0;
        repeat (2) tick();
        rst_n = 1; e_phase = 0; req = 0;
        repeat (3) tick();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule